// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Port

This block is a synchronous serial port with one receive channel and one transmit channel. Each channel sits between a bit-serial line (serial clock, frame and data) and a 32-bit parallel holding register. Received words land in a receive buffer that software or a DMA engine empties. Transmit words are written into a transmit buffer that the shifter takes at the next frame. Each channel has a holding register in front of its shift register, so a new word can be framed on the serial clock edge right after the last bit of the previous word, with no idle bit between them.

The two directions are set up separately from one control register. Receive words are 8, 16 or 32 bits long. Transmit words are 8, 16, 24 or 32 bits long. Each direction selects its own bit order. The receive-full and transmit-empty flags drive two DMA request outputs. They also drive one interrupt line, and each flag has its own enable bit. The serial clocks are inputs that the system clock samples, and rising and falling edges are found by comparing with the previous sample. The block does not generate serial clocks and does not select time slots.

Top module: `serial_io_port`

## Requirements
- R1: After reset the status word (address 3) reads 4 (transmit empty only), the control word reads 0, `tx_sd`, `irq` and `rx_dreq` are low and `tx_dreq` is high.
- R2: Control bits [1:0] set the receive length: 0 gives 8 bits, 1 gives 16 bits, 2 or 3 gives 32 bits. The received word is right-aligned in the receive buffer (address 0) with zeros above it.
- R3: Control bit 2 sets the receive order: 0 means the first bit received becomes the most significant of the word's bits, 1 means it becomes bit 0.
- R4: A rising `rx_sck` edge with `rx_frm` high starts a word, and that edge samples its first bit. Later rising edges sample the following bits. After the last bit the word is copied to the receive buffer and status bit 0 (receive full) is set.
- R5: Reading address 0 clears receive full and the overrun flag (status bit 1). If a word completes while receive full is still set, the overrun flag is set and the new word replaces the old one.
- R6: Control bits [5:4] set the transmit length: 0 gives 8, 1 gives 16, 2 gives 24 and 3 gives 32 bits, taken from the low bits of the transmit buffer.
- R7: Control bit 6 sets the transmit order: 0 sends the most significant of the word's bits first, 1 sends bit 0 first.
- R8: Writing address 1 fills the transmit buffer and clears status bit 2 (transmit empty). A falling `tx_sck` edge with `tx_frm` high moves the buffer into the shifter, drives the first bit and sets transmit empty again. Each later falling edge drives the next bit. After the last bit the next falling edge without a frame drives `tx_sd` low. A frame that finds the buffer empty sends zeros.
- R9: Both directions run back to back: a frame on the edge right after a word's last bit starts the next word with no idle bit.
- R10: `irq` is high when receive full is set with control bit 8, or when transmit empty is set with control bit 9. `rx_dreq` follows receive full and `tx_dreq` follows transmit empty.
- R11: The control word (address 2) reads back the written value masked to bits 0-2, 4-6, 8 and 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 receive buffer, 1 transmit buffer, 2 control, 3 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| rx_sck | input | 1 | Receive serial clock |
| rx_frm | input | 1 | Receive frame, marks a word's first bit |
| rx_sd | input | 1 | Receive serial data |
| tx_sck | input | 1 | Transmit serial clock |
| tx_frm | input | 1 | Transmit frame, starts a word |
| tx_sd | output | 1 | Transmit serial data |
| irq | output | 1 | Enabled flag interrupt |
| rx_dreq | output | 1 | Receive DMA request (buffer full) |
| tx_dreq | output | 1 | Transmit DMA request (buffer empty) |

## Verification
The bench builds the port with its default 32-bit word and 2-bit register address. With these values every receive and transmit length code, including the 24-bit transmit length and the 32-bit length that fills the whole shift register, can be reached through the control word. Serial clocks run at eight system clocks per bit, so each edge is detected well apart from the bus accesses placed between edges. This allows a transmit buffer refill during a word and a completely unread second receive word, which cover the back-to-back and overrun cases.

// File: rtl/serio_pkg.sv
`timescale 1ns/1ps
package serio_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = $clog2(WORD_W) + 1;
  localparam int ADDR_W = 2;

  localparam logic [WORD_W-1:0] CTRL_MASK = 32'h0000_0377;

  typedef enum logic [ADDR_W-1:0] {
    A_RXBUF = 2'd0,
    A_TXBUF = 2'd1,
    A_CTRL  = 2'd2,
    A_STAT  = 2'd3
  } reg_addr_e;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [WORD_W-1:0] word_t;

  function automatic cnt_t rx_len(input logic [1:0] code);
    case (code)
      2'd0:    return cnt_t'(8);
      2'd1:    return cnt_t'(16);
      default: return cnt_t'(WORD_W);
    endcase
  endfunction

  function automatic cnt_t tx_len(input logic [1:0] code);
    case (code)
      2'd0:    return cnt_t'(8);
      2'd1:    return cnt_t'(16);
      2'd2:    return cnt_t'(24);
      default: return cnt_t'(WORD_W);
    endcase
  endfunction

  // place one received bit; words stay right-aligned either way
  function automatic word_t rx_insert(input word_t sh, input logic b,
                                      input cnt_t pos, input logic lsb);
    if (lsb) return sh | (word_t'(b) << pos);
    return {sh[WORD_W-2:0], b};
  endfunction

  // move the word so the first bit to send sits at a fixed end
  function automatic word_t tx_align(input word_t w, input cnt_t len,
                                     input logic lsb);
    if (lsb) return w;
    return w << (cnt_t'(WORD_W) - len);
  endfunction

  function automatic logic tx_head(input word_t v, input logic lsb);
    return lsb ? v[0] : v[WORD_W-1];
  endfunction

  function automatic word_t tx_next(input word_t v, input logic lsb);
    return lsb ? (v >> 1) : (v << 1);
  endfunction
endpackage

// File: rtl/serio_rx.sv
`timescale 1ns/1ps
module serio_rx
  import serio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck,
  input  logic        frm,
  input  logic        sd,
  input  logic [1:0]  len_code,
  input  logic        lsb_first,
  input  logic        rd_clr,
  output word_t       buf_q,
  output logic        full_q,
  output logic        ovr_q,
  output logic        word_done
);
  logic  sck_q, active_q, lsb_q;
  cnt_t  cnt_q, len_q;
  word_t sh_q;

  logic  rise, start, take;
  cnt_t  eff_len, base_cnt;
  logic  eff_lsb;
  word_t base_sh, nsh;

  always_comb begin
    rise     = sck & ~sck_q;
    start    = rise & frm;
    take     = rise & (frm | active_q);
    eff_len  = start ? rx_len(len_code) : len_q;
    eff_lsb  = start ? lsb_first : lsb_q;
    base_sh  = start ? '0 : sh_q;
    base_cnt = start ? '0 : cnt_q;
    nsh      = rx_insert(base_sh, sd, base_cnt, eff_lsb);
    word_done = take & ((base_cnt + cnt_t'(1)) == eff_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      active_q <= 1'b0;
      lsb_q    <= 1'b0;
      cnt_q    <= '0;
      len_q    <= cnt_t'(8);
      sh_q     <= '0;
      buf_q    <= '0;
      full_q   <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      sck_q <= sck;
      if (take) begin
        sh_q     <= nsh;
        cnt_q    <= base_cnt + cnt_t'(1);
        active_q <= ~word_done;
      end
      if (start) begin
        len_q <= eff_len;
        lsb_q <= eff_lsb;
      end
      if (word_done) begin
        buf_q  <= nsh;
        full_q <= 1'b1;
        ovr_q  <= (full_q | ovr_q) & ~rd_clr;
      end else if (rd_clr) begin
        full_q <= 1'b0;
        ovr_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serio_tx.sv
`timescale 1ns/1ps
module serio_tx
  import serio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck,
  input  logic        frm,
  input  logic [1:0]  len_code,
  input  logic        lsb_first,
  input  word_t       buf_data,
  input  logic        buf_full,
  output logic        sd_q,
  output logic        word_load,
  output logic        busy
);
  logic  sck_q, active_q, lsb_q, fall;
  cnt_t  cnt_q, len_q, new_len;
  word_t sh_q, src, aligned;

  always_comb begin
    fall      = ~sck & sck_q;
    word_load = fall & frm;
    new_len   = tx_len(len_code);
    src       = buf_full ? buf_data : '0;
    aligned   = tx_align(src, new_len, lsb_first);
    busy      = active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      active_q <= 1'b0;
      lsb_q    <= 1'b0;
      cnt_q    <= '0;
      len_q    <= cnt_t'(8);
      sh_q     <= '0;
      sd_q     <= 1'b0;
    end else begin
      sck_q <= sck;
      if (word_load) begin
        sd_q     <= tx_head(aligned, lsb_first);
        sh_q     <= tx_next(aligned, lsb_first);
        cnt_q    <= cnt_t'(1);
        len_q    <= new_len;
        lsb_q    <= lsb_first;
        active_q <= 1'b1;
      end else if (fall && active_q) begin
        if (cnt_q == len_q) begin
          active_q <= 1'b0;
          sd_q     <= 1'b0;
        end else begin
          sd_q  <= tx_head(sh_q, lsb_q);
          sh_q  <= tx_next(sh_q, lsb_q);
          cnt_q <= cnt_q + cnt_t'(1);
        end
      end
    end
  end
endmodule

// File: rtl/serio_regs.sv
`timescale 1ns/1ps
module serio_regs
  import serio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  word_t             bus_wdata,
  output word_t             bus_rdata,
  input  word_t             rx_buf,
  input  logic              rx_full,
  input  logic              rx_ovr,
  input  logic              tx_load,
  output word_t             ctrl_q,
  output word_t             tx_buf_q,
  output logic              tx_full_q,
  output logic              rd_clr,
  output logic              tx_wr,
  output logic              irq
);
  logic ctrl_wr;
  word_t status;

  always_comb begin
    rd_clr  = bus_sel & ~bus_wr & (bus_addr == A_RXBUF);
    tx_wr   = bus_sel &  bus_wr & (bus_addr == A_TXBUF);
    ctrl_wr = bus_sel &  bus_wr & (bus_addr == A_CTRL);
    status  = {{(WORD_W-3){1'b0}}, ~tx_full_q, rx_ovr, rx_full};
    case (bus_addr)
      A_RXBUF: bus_rdata = rx_buf;
      A_TXBUF: bus_rdata = tx_buf_q;
      A_CTRL:  bus_rdata = ctrl_q;
      default: bus_rdata = status;
    endcase
    irq = (rx_full & ctrl_q[8]) | (~tx_full_q & ctrl_q[9]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      tx_buf_q  <= '0;
      tx_full_q <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata & CTRL_MASK;
      if (tx_wr) begin
        tx_buf_q  <= bus_wdata;
        tx_full_q <= 1'b1;
      end else if (tx_load) begin
        tx_full_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_io_port.sv
`timescale 1ns/1ps
module serial_io_port
  import serio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              rx_sck,
  input  logic              rx_frm,
  input  logic              rx_sd,
  input  logic              tx_sck,
  input  logic              tx_frm,
  output logic              tx_sd,
  output logic              irq,
  output logic              rx_dreq,
  output logic              tx_dreq
);
  word_t ctrl, rx_buf, tx_buf;
  logic  rx_full, rx_ovr, rx_word_done, rx_rd_clr;
  logic  tx_full, tx_wr, tx_word_load, tx_busy;

  serio_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_buf(rx_buf), .rx_full(rx_full), .rx_ovr(rx_ovr),
    .tx_load(tx_word_load),
    .ctrl_q(ctrl), .tx_buf_q(tx_buf), .tx_full_q(tx_full),
    .rd_clr(rx_rd_clr), .tx_wr(tx_wr), .irq(irq)
  );

  serio_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .sck(rx_sck), .frm(rx_frm), .sd(rx_sd),
    .len_code(ctrl[1:0]), .lsb_first(ctrl[2]),
    .rd_clr(rx_rd_clr),
    .buf_q(rx_buf), .full_q(rx_full), .ovr_q(rx_ovr),
    .word_done(rx_word_done)
  );

  serio_tx u_tx (
    .clk(clk), .rst_n(rst_n),
    .sck(tx_sck), .frm(tx_frm),
    .len_code(ctrl[5:4]), .lsb_first(ctrl[6]),
    .buf_data(tx_buf), .buf_full(tx_full),
    .sd_q(tx_sd), .word_load(tx_word_load), .busy(tx_busy)
  );

  assign rx_dreq = rx_full;
  assign tx_dreq = ~tx_full;
endmodule

// File: rtl/serial_io_port_chk.sv
`timescale 1ns/1ps
module serial_io_port_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_word_done,
  input logic rx_rd_clr,
  input logic rx_full,
  input logic rx_ovr,
  input logic tx_word_load,
  input logic tx_wr,
  input logic tx_full,
  input logic tx_busy,
  input logic tx_sd,
  input logic irq
);
  a_r4_done_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word_done |=> rx_full);

  a_r5_overrun_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_word_done && rx_full && !rx_rd_clr) |=> rx_ovr);

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_clr && !rx_word_done) |=> (!rx_full && !rx_ovr));

  a_r5_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr |-> rx_full);

  a_r8_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> tx_full);

  a_r8_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_word_load && !tx_wr) |=> !tx_full);

  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !tx_sd);

  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_full || !tx_full));
endmodule

bind serial_io_port serial_io_port_chk i_chk (
  .clk(clk), .rst_n(rst_n),
  .rx_word_done(rx_word_done), .rx_rd_clr(rx_rd_clr),
  .rx_full(rx_full), .rx_ovr(rx_ovr),
  .tx_word_load(tx_word_load), .tx_wr(tx_wr), .tx_full(tx_full),
  .tx_busy(tx_busy), .tx_sd(tx_sd), .irq(irq)
);

// File: tb/test_serial_io_port.sv
`timescale 1ns/1ps
module test_serial_io_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_sck = 1'b0, rx_frm = 1'b0, rx_sd = 1'b0;
  logic        tx_sck = 1'b1, tx_frm = 1'b0;
  logic        tx_sd, irq, rx_dreq, tx_dreq;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  serial_io_port i_serial_io_port (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_sck(rx_sck), .rx_frm(rx_frm), .rx_sd(rx_sd),
    .tx_sck(tx_sck), .tx_frm(tx_frm), .tx_sd(tx_sd),
    .irq(irq), .rx_dreq(rx_dreq), .tx_dreq(tx_dreq)
  );

  task automatic check(input string tag, input logic [63:0] got,
                       input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // peek without the read strobe so no flag is cleared
  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_ctrl(input logic [1:0] rxc, input logic rxl,
                          input logic [1:0] txc, input logic txl,
                          input logic ie_rx, input logic ie_tx);
    bus_write(2'd2, {22'd0, ie_tx, ie_rx, 1'b0, txl, txc, 1'b0, rxl, rxc});
  endtask

  task automatic rx_word(input logic [31:0] w, input int n, input logic lsb);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_sd  = lsb ? w[i] : w[n-1-i];
      rx_frm = (i == 0);
      half();
      rx_sck = 1'b1;
      half();
      rx_sck = 1'b0;
      rx_frm = 1'b0;
    end
  endtask

  task automatic tx_get(input int n, input int words, input logic [31:0] second,
                        output logic [63:0] bits, output logic idle_sd);
    bits = '0;
    for (int i = 0; i < n*words; i++) begin
      @(negedge clk);
      tx_sck = 1'b0;
      tx_frm = ((i % n) == 0);
      half();
      bits[i] = tx_sd;
      if (words == 2 && i == 1) bus_write(2'd1, second);
      tx_sck = 1'b1;
      tx_frm = 1'b0;
      half();
    end
    @(negedge clk);
    tx_sck = 1'b0;
    half();
    idle_sd = tx_sd;
    tx_sck = 1'b1;
    half();
  endtask

  function automatic logic [31:0] rebuild(input logic [63:0] bits, input int base,
                                          input int n, input logic lsb);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) begin
      if (lsb) v[i] = bits[base+i];
      else     v = {v[30:0], bits[base+i]};
    end
    return v;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    peek(2'd3, d); check("R1 status", d, 32'h4);
    peek(2'd2, d); check("R1 ctrl", d, 32'h0);
    check("R1 tx_sd", tx_sd, 0);
    check("R1 irq", irq, 0);
    check("R1 rx_dreq", rx_dreq, 0);
    check("R1 tx_dreq", tx_dreq, 1);
  endtask

  task automatic t_rx_lengths();
    logic [31:0] d;
    set_ctrl(2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    rx_word(32'hFFFF_FFB4, 8, 1'b0);
    half();
    check("R4 full after word", rx_dreq, 1);
    bus_read(2'd0, d); check("R2 8-bit msb", d, 32'h0000_00B4);
    check("R5 read clears full", rx_dreq, 0);
    set_ctrl(2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    rx_word(32'hFFFF_9C3E, 16, 1'b0);
    half();
    bus_read(2'd0, d); check("R2 16-bit msb", d, 32'h0000_9C3E);
    set_ctrl(2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    rx_word(32'hDEAD_B00F, 32, 1'b0);
    half();
    bus_read(2'd0, d); check("R2 32-bit msb", d, 32'hDEAD_B00F);
  endtask

  task automatic t_rx_lsb();
    logic [31:0] d;
    set_ctrl(2'd1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
    rx_word(32'h0000_1203, 16, 1'b1);
    half();
    bus_read(2'd0, d); check("R3 16-bit lsb", d, 32'h0000_1203);
    set_ctrl(2'd3, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
    rx_word(32'h8421_0F1E, 32, 1'b1);
    half();
    bus_read(2'd0, d); check("R3 32-bit lsb code3", d, 32'h8421_0F1E);
  endtask

  task automatic t_rx_overrun();
    logic [31:0] d;
    set_ctrl(2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    rx_word(32'h0000_0011, 8, 1'b0);
    rx_word(32'h0000_00E7, 8, 1'b0);
    half();
    peek(2'd3, d); check("R5 overrun flag", d[1:0], 2'b11);
    bus_read(2'd0, d); check("R9 R5 second word kept", d, 32'h0000_00E7);
    peek(2'd3, d); check("R5 read clears overrun", d[1:0], 2'b00);
  endtask

  task automatic t_tx_modes();
    logic [63:0] b;
    logic idle, d;
    logic [31:0] r;
    set_ctrl(2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    bus_write(2'd1, 32'h1234_56C5);
    peek(2'd3, r); check("R8 write clears empty", r[2], 0);
    tx_get(8, 1, 32'h0, b, idle);
    check("R6 8-bit msb", rebuild(b, 0, 8, 1'b0), 32'hC5);
    check("R8 idle low", idle, 0);
    check("R8 empty after load", tx_dreq, 1);
    set_ctrl(2'd0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0);
    bus_write(2'd1, 32'hA5C3_965A);
    tx_get(24, 1, 32'h0, b, idle);
    check("R6 24-bit msb", rebuild(b, 0, 24, 1'b0), 32'h00C3_965A);
    set_ctrl(2'd0, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0);
    bus_write(2'd1, 32'h0F00_8001);
    tx_get(32, 1, 32'h0, b, idle);
    check("R7 32-bit lsb", rebuild(b, 0, 32, 1'b1), 32'h0F00_8001);
    check("R7 lsb first bit", b[0], 1);
    set_ctrl(2'd0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0);
    bus_write(2'd1, 32'hFFFF_3A61);
    tx_get(16, 1, 32'h0, b, d);
    check("R7 16-bit lsb", rebuild(b, 0, 16, 1'b1), 32'h3A61);
    tx_get(8, 1, 32'h0, b, d);
    check("R8 underrun sends zeros", b[15:0], 16'h0);
  endtask

  task automatic t_tx_b2b();
    logic [63:0] b;
    logic idle;
    set_ctrl(2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    bus_write(2'd1, 32'h0000_0096);
    tx_get(8, 2, 32'h0000_003C, b, idle);
    check("R9 tx first word", rebuild(b, 0, 8, 1'b0), 32'h96);
    check("R9 tx second word", rebuild(b, 8, 8, 1'b0), 32'h3C);
    check("R9 tx idle after pair", idle, 0);
  endtask

  task automatic t_irq_ctrl();
    logic [31:0] d;
    set_ctrl(2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1);
    check("R10 irq tx empty", irq, 1);
    check("R10 tx_dreq", tx_dreq, 1);
    set_ctrl(2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0);
    check("R10 irq masked", irq, 0);
    rx_word(32'h5A, 8, 1'b0);
    half();
    check("R10 irq rx full", irq, 1);
    check("R10 rx_dreq", rx_dreq, 1);
    bus_read(2'd0, d);
    check("R10 irq after read", irq, 0);
    bus_write(2'd2, 32'hFFFF_FFFF);
    peek(2'd2, d); check("R11 ctrl mask", d, 32'h0000_0377);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_rx_lengths();
    t_rx_lsb();
    t_rx_overrun();
    t_tx_modes();
    t_tx_b2b();
    t_irq_ctrl();
    finish_up();
  end
endmodule